// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block is a memory-mapped slave that gives a host indirect access to the 16-bit internal control-register space of a serial PHY. The host never addresses PHY registers directly. It loads a value into a data-in scratch register and then sets one of four command bits: capture address, capture data, read or write. The bridge turns each command into a request/acknowledge handshake on a narrow parallel bus toward the PHY. Read results are returned in a data-out register.

Each command bit is also the busy flag for its step. It stays set while the step is outstanding and clears by itself once the PHY acknowledges, so a host polls it for zero. To write, the host captures an address, then captures data, then issues write. To read, it captures an address, issues read and then fetches data-out. Per-lane PHY registers sit 0x100 apart, and the bridge treats any 16-bit value as a valid PHY address. A cycle budget bounds every step, so the busy flag always clears well within the time a host is willing to wait.

Top module: `phy_cr_bridge`

## Requirements
- R1: After reset, every host-visible register reads 0 and all four PHY strobes are low.
- R2: Byte offset 0x0C is the data-in register. It holds the full 32-bit word last written and reads it back. Its low 16 bits drive `phy_wdata`.
- R3: Byte offset 0x10 is data-out. Host writes to it have no effect. It keeps the most recent read result until the next read completes. Unmapped offsets read 0.
- R4: Command bits sit in bit 0 of four registers: 0x14 capture address, 0x18 capture data, 0x1C read, 0x20 write. Writing 1 to bit 0 starts the step, and bit 0 reads 1 while that step is pending. A write with bit 0 clear does nothing.
- R5: A started step raises exactly one PHY strobe, the one for its kind (`phy_cap_addr`, `phy_cap_data`, `phy_rd` or `phy_wr`). The strobe is held high and unchanged until `phy_ack` is sampled high.
- R6: On the first clock edge at which `phy_ack` is sampled high while a strobe is driven, the strobe drops and the command bit clears. For a read step, data-out loads `phy_rdata` at that same edge.
- R7: A strobe is never raised while `phy_ack` is still high from the previous step. A step accepted then stays pending, with its bit reading 1, and its strobe rises the cycle after `phy_ack` is sampled low.
- R8: A command write that arrives while any step is pending is ignored. This includes the edge at which the pending step completes.
- R9: If a step is still pending MAX_WAIT cycles after it was accepted, its strobe drops, its bit clears and data-out is left unchanged.
- R10: Full write and read sequences move data to and from the PHY register file. Repeating the read command without a new address capture re-reads the same PHY register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write enable for one cycle |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | REG_W | Host write data |
| host_rdata | output | REG_W | Read data for `host_addr` (combinational) |
| phy_wdata | output | DATA_W | Address or data value offered to the PHY |
| phy_cap_addr | output | 1 | PHY strobe: latch address |
| phy_cap_data | output | 1 | PHY strobe: latch data |
| phy_rd | output | 1 | PHY strobe: read latched address |
| phy_wr | output | 1 | PHY strobe: write latched data to latched address |
| phy_rdata | input | DATA_W | PHY read result, valid with `phy_ack` |
| phy_ack | input | 1 | PHY acknowledge |

## Verification
Two events can land on the same clock edge: the PHY's acknowledge completing a pending step, and a new command write from the host. The bench raises the acknowledge by hand and presents a read command in the very cycle of that edge. The pending step must finish normally. The new command must leave no trace: its bit reads 0 and its strobe stays low afterwards. A related overlap, a command issued while the previous acknowledge is still high, is checked by watching that the strobe is held back until the acknowledge falls.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_CAP_ADDR = 3'd1,
        OP_CAP_DATA = 3'd2,
        OP_READ     = 3'd3,
        OP_WRITE    = 3'd4
    } cr_op_e;

    localparam int NUM_OPS = 4;

    localparam logic [7:0] OFS_DIN      = 8'h0C;
    localparam logic [7:0] OFS_DOUT     = 8'h10;
    localparam logic [7:0] OFS_CAP_ADDR = 8'h14;
    localparam logic [7:0] OFS_CAP_DATA = 8'h18;
    localparam logic [7:0] OFS_READ     = 8'h1C;
    localparam logic [7:0] OFS_WRITE    = 8'h20;
endpackage

// File: rtl/cr_host_regs.sv
module cr_host_regs
    import phy_cr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  cr_op_e            pend_op,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] phy_rdata,
    output cr_op_e            req_op,
    output logic [REG_W-1:0]  rdata,
    output logic [DATA_W-1:0] din
);
    typedef struct packed {
        logic [REG_W-1:0]  din;
        logic [DATA_W-1:0] dout;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en && addr == ADDR_W'(OFS_DIN)) d.din = wdata;
        if (rd_done) d.dout = phy_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req_op = OP_NONE;
        if (wr_en && wdata[0]) begin
            case (addr)
                ADDR_W'(OFS_CAP_ADDR): req_op = OP_CAP_ADDR;
                ADDR_W'(OFS_CAP_DATA): req_op = OP_CAP_DATA;
                ADDR_W'(OFS_READ):     req_op = OP_READ;
                ADDR_W'(OFS_WRITE):    req_op = OP_WRITE;
                default:               req_op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_DIN):      rdata = q.din;
            ADDR_W'(OFS_DOUT):     rdata = REG_W'(q.dout);
            ADDR_W'(OFS_CAP_ADDR): rdata = REG_W'(pend_op == OP_CAP_ADDR);
            ADDR_W'(OFS_CAP_DATA): rdata = REG_W'(pend_op == OP_CAP_DATA);
            ADDR_W'(OFS_READ):     rdata = REG_W'(pend_op == OP_READ);
            ADDR_W'(OFS_WRITE):    rdata = REG_W'(pend_op == OP_WRITE);
            default:               rdata = '0;
        endcase
    end

    assign din = q.din[DATA_W-1:0];

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(q.dout));
    // R6
    dout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> q.dout == $past(phy_rdata));
endmodule

// File: rtl/cr_handshake.sv
module cr_handshake
    import phy_cr_pkg::*;
#(
    parameter int MAX_WAIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cr_op_e             req_op,
    input  logic               phy_ack,
    output cr_op_e             pend_op,
    output logic               rd_done,
    output logic [NUM_OPS-1:0] strobes
);
    localparam int CNT_W = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT - 1);

    typedef struct packed {
        cr_op_e           op;
        logic             drive;
        logic [CNT_W-1:0] cnt;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d = q;
        rd_done = 1'b0;
        if (q.op == OP_NONE) begin
            if (req_op != OP_NONE) begin
                d.op    = req_op;
                d.drive = !phy_ack;
                d.cnt   = '0;
            end
        end else if (q.drive && phy_ack) begin
            d.op    = OP_NONE;
            d.drive = 1'b0;
            rd_done = (q.op == OP_READ);
        end else if (q.cnt == LIMIT) begin
            d.op    = OP_NONE;
            d.drive = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (!q.drive && !phy_ack) d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{op: OP_NONE, drive: 1'b0, cnt: '0};
        else        q <= d;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_strobe
        assign strobes[i] = q.drive && (q.op == cr_op_e'(3'(i + 1)));
    end

    assign pend_op = q.op;

    // R5
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes && !phy_ack && q.cnt != LIMIT) |=> $stable(strobes));
    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes && phy_ack) |=> (strobes == '0 && pend_op == OP_NONE));
    // R7
    rise_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|strobes) |-> !$past(phy_ack));
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op != OP_NONE && !(q.drive && phy_ack) && q.cnt != LIMIT) |=> $stable(pend_op));
    // R9
    budget_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op != OP_NONE && q.cnt == LIMIT && !(q.drive && phy_ack)) |=> (pend_op == OP_NONE && strobes == '0));
endmodule

// File: rtl/phy_cr_bridge.sv
module phy_cr_bridge
    import phy_cr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_W    = 32,
    parameter int DATA_W   = 16,
    parameter int MAX_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_rd,
    output logic              phy_wr,
    input  logic [DATA_W-1:0] phy_rdata,
    input  logic              phy_ack
);
    cr_op_e             req_op;
    cr_op_e             pend_op;
    logic               rd_done;
    logic [NUM_OPS-1:0] strobes;

    cr_host_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .pend_op   (pend_op),
        .rd_done   (rd_done),
        .phy_rdata (phy_rdata),
        .req_op    (req_op),
        .rdata     (host_rdata),
        .din       (phy_wdata)
    );

    cr_handshake #(.MAX_WAIT(MAX_WAIT)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_op  (req_op),
        .phy_ack (phy_ack),
        .pend_op (pend_op),
        .rd_done (rd_done),
        .strobes (strobes)
    );

    assign phy_cap_addr = strobes[0];
    assign phy_cap_data = strobes[1];
    assign phy_rd       = strobes[2];
    assign phy_wr       = strobes[3];
endmodule

// File: tb/test_phy_cr_bridge.sv
`timescale 1ns/1ps
module test_phy_cr_bridge;
    import phy_cr_pkg::*;

    localparam int MAXW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] phy_wdata;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic [15:0] phy_rdata;
    logic        phy_ack;

    logic        manual = 1'b1;
    logic        ack_man = 1'b0;
    logic [15:0] rdata_man = '0;
    logic        ack_mdl;
    logic [15:0] rdata_mdl;
    int          lat = 0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] ref_mem [0:255];

    always #4 clk = ~clk;

    assign phy_ack   = manual ? ack_man : ack_mdl;
    assign phy_rdata = manual ? rdata_man : rdata_mdl;

    phy_cr_bridge #(.ADDR_W(8), .REG_W(32), .DATA_W(16), .MAX_WAIT(MAXW)) i_phy_cr_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_wdata(phy_wdata),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data), .phy_rd(phy_rd),
        .phy_wr(phy_wr), .phy_rdata(phy_rdata), .phy_ack(phy_ack)
    );

    function automatic logic [7:0] idx(input logic [15:0] a);
        return {a[9:8], a[5:0]};
    endfunction

    function automatic logic [15:0] pick_addr(input int k, input int lane);
        logic [15:0] b;
        case (k)
            0: b = 16'h1002;
            1: b = 16'h1006;
            2: b = 16'h1010;
            3: b = 16'h102D;
            default: b = 16'h0030;
        endcase
        return b + 16'(lane * 16'h0100);
    endfunction

    // PHY register-file model
    logic [15:0] m_addr, m_data;
    logic [15:0] m_mem [0:255];
    int          m_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_mdl <= 1'b0; rdata_mdl <= '0; m_addr <= '0; m_data <= '0; m_cnt <= 0;
            for (int i = 0; i < 256; i++) m_mem[i] <= '0;
        end else if (!(phy_cap_addr | phy_cap_data | phy_rd | phy_wr)) begin
            ack_mdl <= 1'b0;
            m_cnt   <= 0;
        end else if (!ack_mdl && !manual) begin
            if (m_cnt >= lat) begin
                ack_mdl <= 1'b1;
                m_cnt   <= 0;
                if (phy_cap_addr) m_addr <= phy_wdata;
                if (phy_cap_data) m_data <= phy_wdata;
                if (phy_wr) m_mem[idx(m_addr)] <= m_data;
                if (phy_rd) rdata_mdl <= m_mem[idx(m_addr)];
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic poll(input logic [7:0] a, output int busy);
        logic [31:0] v;
        busy = 0;
        for (int i = 0; i < 200; i++) begin
            host_read(a, v);
            if (v[0] == 1'b0) break;
            busy++;
        end
    endtask

    task automatic cr_write(input logic [15:0] a, input logic [15:0] v);
        int b;
        host_write(OFS_DIN, 32'(a));   host_write(OFS_CAP_ADDR, 1); poll(OFS_CAP_ADDR, b);
        host_write(OFS_DIN, 32'(v));   host_write(OFS_CAP_DATA, 1); poll(OFS_CAP_DATA, b);
        host_write(OFS_WRITE, 1);      poll(OFS_WRITE, b);
        check(b < MAXW - 2, "R10 write step finished by ack", b, MAXW);
        ref_mem[idx(a)] = v;
    endtask

    task automatic cr_read_again(output logic [31:0] v);
        int b;
        host_write(OFS_READ, 1); poll(OFS_READ, b);
        host_read(OFS_DOUT, v);
    endtask

    task automatic cr_read(input logic [15:0] a, output logic [31:0] v);
        int b;
        host_write(OFS_DIN, 32'(a)); host_write(OFS_CAP_ADDR, 1); poll(OFS_CAP_ADDR, b);
        cr_read_again(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int b;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(OFS_DIN, v);      check(v == 0, "R1 data-in", v, 0);
        host_read(OFS_DOUT, v);     check(v == 0, "R1 data-out", v, 0);
        host_read(OFS_CAP_ADDR, v); check(v == 0, "R1 cap-addr bit", v, 0);
        host_read(OFS_WRITE, v);    check(v == 0, "R1 write bit", v, 0);
        check({phy_cap_addr, phy_cap_data, phy_rd, phy_wr} == 0, "R1 strobes",
              {phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 0);

        // R2 data-in
        host_write(OFS_DIN, 32'hABCD_1234);
        host_read(OFS_DIN, v); check(v == 32'hABCD_1234, "R2 data-in readback", v, 32'hABCD_1234);
        check(phy_wdata == 16'h1234, "R2 phy_wdata", phy_wdata, 16'h1234);

        // R3 data-out write ignored, unmapped reads 0
        host_write(OFS_DOUT, 32'hFFFF_FFFF);
        host_read(OFS_DOUT, v); check(v == 0, "R3 data-out not writable", v, 0);
        host_read(8'h04, v);    check(v == 0, "R3 unmapped offset", v, 0);

        // R4 bit0 clear ignored
        host_write(OFS_CAP_ADDR, 32'h2);
        host_read(OFS_CAP_ADDR, v); check(v == 0, "R4 bit0 clear ignored", v, 0);
        check(phy_cap_addr == 0, "R4 no strobe", phy_cap_addr, 0);

        // R4/R5 capture address with manual PHY
        host_write(OFS_CAP_ADDR, 1);
        check(phy_cap_addr == 1 && phy_wdata == 16'h1234, "R5 cap-addr strobe", {phy_cap_addr, phy_wdata}, {1'b1, 16'h1234});
        host_read(OFS_CAP_ADDR, v); check(v == 1, "R4 cap-addr busy", v, 1);
        repeat (3) @(negedge clk);
        check(phy_cap_addr == 1 && {phy_cap_data, phy_rd, phy_wr} == 0, "R5 strobe held alone",
              {phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 4'b1000);

        // R8 command while pending
        host_write(OFS_WRITE, 1);
        host_read(OFS_WRITE, v); check(v == 0, "R8 write cmd ignored while busy", v, 0);
        check(phy_wr == 0, "R8 no write strobe", phy_wr, 0);

        // R6 ack completes
        @(negedge clk); ack_man = 1'b1;
        @(negedge clk);
        check(phy_cap_addr == 0, "R6 strobe drops after ack", phy_cap_addr, 0);
        host_read(OFS_CAP_ADDR, v); check(v == 0, "R6 busy clears", v, 0);

        // R7 new step while ack still high
        host_write(OFS_DIN, 32'h0000_00A5);
        host_write(OFS_CAP_DATA, 1);
        host_read(OFS_CAP_DATA, v); check(v == 1, "R7 pending while ack high", v, 1);
        check(phy_cap_data == 0, "R7 strobe held back", phy_cap_data, 0);
        repeat (2) @(negedge clk);
        check(phy_cap_data == 0, "R7 strobe still held back", phy_cap_data, 0);
        ack_man = 1'b0;
        @(negedge clk);
        check(phy_cap_data == 1, "R7 strobe after ack drop", phy_cap_data, 1);

        // R8 collision: read command on the completing edge
        @(negedge clk);
        ack_man = 1'b1; host_wr = 1'b1; host_addr = OFS_READ; host_wdata = 1;
        @(negedge clk);
        host_wr = 1'b0; ack_man = 1'b0;
        check(phy_cap_data == 0, "R6 cap-data completed", phy_cap_data, 0);
        repeat (2) @(negedge clk);
        check(phy_rd == 0, "R8 colliding read has no strobe", phy_rd, 0);
        host_read(OFS_READ, v); check(v == 0, "R8 colliding read bit", v, 0);

        // R6 read result capture
        rdata_man = 16'hBEEF;
        host_write(OFS_READ, 1);
        check(phy_rd == 1, "R5 read strobe", phy_rd, 1);
        @(negedge clk); ack_man = 1'b1;
        @(negedge clk); ack_man = 1'b0; rdata_man = 16'h5555;
        check(phy_rd == 0, "R6 read strobe drops", phy_rd, 0);
        host_read(OFS_DOUT, v); check(v == 32'hBEEF, "R6 data-out loaded", v, 32'hBEEF);

        // R9 timeout, no ack
        host_write(OFS_READ, 1);
        poll(OFS_READ, b);
        check(b >= MAXW - 3 && b <= MAXW + 1, "R9 busy bounded by budget", b, MAXW);
        check(phy_rd == 0, "R9 strobe dropped", phy_rd, 0);
        host_read(OFS_DOUT, v); check(v == 32'hBEEF, "R9 data-out unchanged", v, 32'hBEEF);

        // R10 model-based transactions
        manual = 1'b0;
        @(negedge clk);
        cr_write(16'h1006, 16'h0F0F);
        cr_write(16'h1106, 16'h7777);
        cr_read(16'h1006, v); check(v == 32'h0F0F, "R10 lane0 read", v, 32'h0F0F);
        cr_read(16'h1106, v); check(v == 32'h7777, "R10 lane1 read", v, 32'h7777);
        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            logic [31:0] e;
            int k;
            lat = int'($urandom % 7);
            a = pick_addr(int'($urandom % 5), int'($urandom % 4));
            k = int'($urandom % 3);
            if (k == 0) begin
                cr_write(a, 16'($urandom));
            end else begin
                e = 32'(ref_mem[idx(a)]);
                cr_read(a, v); check(v == e, "R10 random read", v, e);
                if (k == 2) begin
                    cr_read_again(v); check(v == e, "R10 re-read same address", v, e);
                end
            end
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule